// File: doc/BRIEF.md
# Domain Access Error Capture Unit

This block sits beside a set of access-protection checkers and keeps a record of the violations they report. A checker signals a violation with a one-cycle valid pulse. The pulse carries the faulting address, the domain ID of the access, the port it came in on, whether it was a read or a write, and two attribute bits (privileged, secure). The block holds one error record per checker. It exposes, for every domain, a location bitmap that shows which checkers currently hold a pending error owned by that domain.

Software services errors one domain at a time:

1. It reads the bitmap of the domain and takes the highest set bit as the checker to service.
2. It writes the domain into the domain-select register.
3. It reads the error words of that checker.
4. It writes a one to the clear bit in the checker's word 3.

A record is captured only while the checker has nothing pending. Later violations on the same checker are not stored. They only mark the record as overrun.

The register port is addressed by word index, which is the byte offset divided by four. Reads are combinational. Writes take effect at the clock edge. The write data is 8 bits wide and the read data is 32 bits wide.

Top module: `errcap_top`

## Requirements
- R1: The configuration word at byte offset 0x000 reads {memory checkers-1, peripheral checkers-1, domains-1, masters-1}, one byte per field, with the memory-checker byte in bits 31:24. With the default parameters it reads 0x01010302.
- R2: After reset every domain bitmap reads zero and the domain-select register (byte offset 0x004, 8 bits, readable) reads zero.
- R3: A violation pulse on checker c that has no pending error captures the record. From the next cycle, bit c of the bitmap of the violation's domain is set.
- R4: The bitmap of domain d is at byte offset 0x100+4d. Bit c is set exactly when checker c holds a pending error whose domain is d. Several checkers can be set at once, and the highest set bit names the checker to service first.
- R5: The error words of checker c are at byte offset 0x200+16c+4w. They return data only when checker c is pending and its record's domain equals the selected domain. Otherwise they read zero.
- R6: Word 0 returns the faulting address. Word 1 returns the domain in bits 3:0, the write flag in bit 4 (1 = write), the attributes in bits 6:5, the port in bits 11:8 and the state in bits 31:30 (01 = pending, 11 = pending with a later violation lost). All other bits of word 1 are zero. Word 2 reads zero.
- R7: While an error is pending on a checker, further violations on that checker leave its record and its bitmap bit unchanged and set the state to 11.
- R8: Writing a value with bit 0 set to word 3 of checker c clears its pending error only when the record's domain is the selected domain. A write with bit 0 clear, or a write while another domain is selected, has no effect.
- R9: With the domain-select value at or above the domain count, all error words read zero and clear writes have no effect.
- R10: A violation and an accepted clear on the same checker in the same cycle leave the checker pending with the new record and state 01.
- R11: After a clear, the next violation on that checker is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vioValid | input | NUM_CHK | Violation pulse, one bit per checker |
| vioAddr | input | NUM_CHK*ADDR_W | Faulting address per checker |
| vioDomain | input | NUM_CHK*4 | Domain ID per checker |
| vioPort | input | NUM_CHK*4 | Port number per checker |
| vioWrite | input | NUM_CHK | 1 = write access, 0 = read |
| vioAttr | input | NUM_CHK*2 | Privileged/secure attribute bits per checker |
| regIdx | input | 10 | Register word index (byte offset / 4) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 32 | Register read data for regIdx |

## Verification
The tests use the following patterns:

- **Single violation.** One violation on an idle checker shows capture and the field packing of word 1.
- **Repeat violation.** A second violation on the same checker separates first-error capture from overwrite, and shows the overrun state.
- **Two checkers in one cycle.** Two checkers reporting in one domain at once separate a true per-checker bitmap from a single shared error slot.
- **Domain windowing.** Reads and clears with the wrong domain selected, with an out-of-range domain selected, and with clear bit 0 low show that the selection gates both reads and clears.
- **Simultaneous violation and clear.** A violation that lands in the same cycle as the clear separates "new record wins" from "clear wins".

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int MAX_CHK = 16;
  localparam int DOM_W   = 4;
  localparam int PORT_W  = 4;
  localparam int ATTR_W  = 2;

  // register pages selected by regIdx[9:6]
  localparam logic [3:0] PAGE_GLOBAL = 4'h0;
  localparam logic [3:0] PAGE_BITMAP = 4'h1;
  localparam logic [3:0] PAGE_ERROR  = 4'h2;

  // state codes in word 1
  localparam logic [1:0] ST_PEND    = 2'b01;
  localparam logic [1:0] ST_OVERRUN = 2'b11;

  typedef struct packed {
    logic [MAX_CHK-1:0] clrHit;
  } ctlStrobes_t;
endpackage

// File: rtl/errcap_records.sv
module errcap_records
  import errcap_pkg::*;
#(
  parameter int NUM_CHK = 4,
  parameter int ADDR_W  = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CHK-1:0]                 vioValid,
  input  logic [NUM_CHK-1:0][ADDR_W-1:0]     vioAddr,
  input  logic [NUM_CHK-1:0][DOM_W-1:0]      vioDomain,
  input  logic [NUM_CHK-1:0][PORT_W-1:0]     vioPort,
  input  logic [NUM_CHK-1:0]                 vioWrite,
  input  logic [NUM_CHK-1:0][ATTR_W-1:0]     vioAttr,
  input  ctlStrobes_t                        strobes,
  output logic [NUM_CHK-1:0]                 recPend,
  output logic [NUM_CHK-1:0][DOM_W-1:0]      recDom,
  output logic [NUM_CHK-1:0][ADDR_W-1:0]     recAddr,
  output logic [NUM_CHK-1:0][31:0]           recWord1
);
  for (genvar c = 0; c < NUM_CHK; c++) begin : gChk
    logic              ovr;
    logic [PORT_W-1:0] port;
    logic              wrFlag;
    logic [ATTR_W-1:0] attr;
    logic              clr;
    logic              take;

    assign clr  = strobes.clrHit[c];
    assign take = vioValid[c] && (!recPend[c] || clr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        recPend[c] <= 1'b0;
        ovr        <= 1'b0;
        recDom[c]  <= '0;
        recAddr[c] <= '0;
        port       <= '0;
        wrFlag     <= 1'b0;
        attr       <= '0;
      end else if (take) begin
        recPend[c] <= 1'b1;
        ovr        <= 1'b0;
        recDom[c]  <= vioDomain[c];
        recAddr[c] <= vioAddr[c];
        port       <= vioPort[c];
        wrFlag     <= vioWrite[c];
        attr       <= vioAttr[c];
      end else if (clr) begin
        recPend[c] <= 1'b0;
        ovr        <= 1'b0;
      end else if (vioValid[c]) begin
        ovr        <= 1'b1;
      end
    end

    assign recWord1[c] = {(ovr ? ST_OVERRUN : ST_PEND), 18'b0, port, 1'b0,
                          attr, wrFlag, recDom[c]};
  end
endmodule

// File: rtl/errcap_regif.sv
module errcap_regif
  import errcap_pkg::*;
#(
  parameter int NUM_CHK    = 4,
  parameter int NUM_DOM    = 4,
  parameter int NUM_MASTER = 3,
  parameter int NUM_PAC    = 2,
  parameter int NUM_MRC    = 2,
  parameter int ADDR_W     = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [9:0]                     regIdx,
  input  logic                           regWrEn,
  input  logic [7:0]                     regWrData,
  input  logic [NUM_CHK-1:0]             recPend,
  input  logic [NUM_CHK-1:0][DOM_W-1:0]  recDom,
  input  logic [NUM_CHK-1:0][ADDR_W-1:0] recAddr,
  input  logic [NUM_CHK-1:0][31:0]       recWord1,
  output ctlStrobes_t                    strobes,
  output logic [7:0]                     domSel,
  output logic [31:0]                    regRdData
);
  localparam logic [31:0] CFG_WORD = {8'(NUM_MRC - 1), 8'(NUM_PAC - 1),
                                      8'(NUM_DOM - 1), 8'(NUM_MASTER - 1)};

  logic [3:0] page;
  logic [3:0] chkIdx;
  logic [1:0] wordIdx;
  logic       selInRange;
  logic [NUM_CHK-1:0] hit;
  logic [NUM_DOM-1:0][31:0] bitmap;

  assign page       = regIdx[9:6];
  assign chkIdx     = regIdx[5:2];
  assign wordIdx    = regIdx[1:0];
  assign selInRange = (domSel < 8'(NUM_DOM));

  always_ff @(posedge clk) begin
    if (!rstN) domSel <= '0;
    else if (regWrEn && page == PAGE_GLOBAL && regIdx[5:0] == 6'd1) domSel <= regWrData;
  end

  for (genvar c = 0; c < NUM_CHK; c++) begin : gHit
    assign hit[c] = recPend[c] && selInRange && (recDom[c] == domSel[DOM_W-1:0]);
  end

  always_comb begin
    strobes = '0;
    for (int c = 0; c < NUM_CHK; c++) begin
      strobes.clrHit[c] = regWrEn && page == PAGE_ERROR && chkIdx == 4'(c) &&
                          wordIdx == 2'd3 && regWrData[0] && hit[c];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : gMap
    always_comb begin
      bitmap[d] = '0;
      for (int c = 0; c < NUM_CHK; c++) begin
        bitmap[d][c] = recPend[c] && (recDom[c] == DOM_W'(d));
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (page == PAGE_GLOBAL) begin
      if (regIdx[5:0] == 6'd0)      regRdData = CFG_WORD;
      else if (regIdx[5:0] == 6'd1) regRdData = {24'b0, domSel};
    end else if (page == PAGE_BITMAP) begin
      for (int d = 0; d < NUM_DOM; d++) begin
        if (regIdx[5:0] == 6'(d)) regRdData = bitmap[d];
      end
    end else if (page == PAGE_ERROR) begin
      for (int c = 0; c < NUM_CHK; c++) begin
        if (chkIdx == 4'(c) && hit[c]) begin
          if (wordIdx == 2'd0)      regRdData = 32'(recAddr[c]);
          else if (wordIdx == 2'd1) regRdData = recWord1[c];
        end
      end
    end
  end
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int NUM_MASTER = 3,
  parameter int NUM_DOM    = 4,
  parameter int NUM_PAC    = 2,
  parameter int NUM_MRC    = 2,
  parameter int ADDR_W     = 32,
  localparam int NUM_CHK   = NUM_PAC + NUM_MRC
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CHK-1:0]          vioValid,
  input  logic [NUM_CHK*ADDR_W-1:0]   vioAddr,
  input  logic [NUM_CHK*4-1:0]        vioDomain,
  input  logic [NUM_CHK*4-1:0]        vioPort,
  input  logic [NUM_CHK-1:0]          vioWrite,
  input  logic [NUM_CHK*2-1:0]        vioAttr,
  input  logic [9:0]                  regIdx,
  input  logic                        regWrEn,
  input  logic [7:0]                  regWrData,
  output logic [31:0]                 regRdData
);
  ctlStrobes_t                    strobes;
  logic [NUM_CHK-1:0]             recPend;
  logic [NUM_CHK-1:0][DOM_W-1:0]  recDom;
  logic [NUM_CHK-1:0][ADDR_W-1:0] recAddr;
  logic [NUM_CHK-1:0][31:0]       recWord1;
  logic [7:0]                     domSel;
  logic [NUM_CHK-1:0]             clrVec;

  assign clrVec = strobes.clrHit[NUM_CHK-1:0];

  errcap_records #(.NUM_CHK(NUM_CHK), .ADDR_W(ADDR_W)) records_i (
    .clk(clk), .rstN(rstN),
    .vioValid(vioValid), .vioAddr(vioAddr), .vioDomain(vioDomain),
    .vioPort(vioPort), .vioWrite(vioWrite), .vioAttr(vioAttr),
    .strobes(strobes),
    .recPend(recPend), .recDom(recDom), .recAddr(recAddr), .recWord1(recWord1)
  );

  errcap_regif #(.NUM_CHK(NUM_CHK), .NUM_DOM(NUM_DOM), .NUM_MASTER(NUM_MASTER),
                 .NUM_PAC(NUM_PAC), .NUM_MRC(NUM_MRC), .ADDR_W(ADDR_W)) regif_i (
    .clk(clk), .rstN(rstN),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData),
    .recPend(recPend), .recDom(recDom), .recAddr(recAddr), .recWord1(recWord1),
    .strobes(strobes), .domSel(domSel), .regRdData(regRdData)
  );
endmodule

// File: rtl/errcap_sva.sv
module errcap_sva #(
  parameter int NUM_CHK = 4,
  parameter int NUM_DOM = 4,
  parameter int ADDR_W  = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_CHK-1:0]             vioValid,
  input logic [NUM_CHK-1:0]             recPend,
  input logic [NUM_CHK-1:0][ADDR_W-1:0] recAddr,
  input logic [NUM_CHK-1:0]             clrVec,
  input logic [7:0]                     domSel,
  input logic [9:0]                     regIdx,
  input logic [31:0]                    regRdData
);
  for (genvar c = 0; c < NUM_CHK; c++) begin : gProp
    // R3: a violation always leaves the checker pending
    assert_capture_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
      vioValid[c] |=> recPend[c]);
    // R7: a pending record without a clear keeps its address
    assert_first_error_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (recPend[c] && !clrVec[c]) |=> $stable(recAddr[c]));
    // R8: a clear without a new violation empties the checker
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[c] && !vioValid[c]) |=> !recPend[c]);
    // R8: a clear strobe only targets a pending record
    assert_clear_needs_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
      clrVec[c] |-> recPend[c]);
    // R9: no clear while the selection is out of range
    assert_no_clear_oor_R9: assert property (@(posedge clk) disable iff (!rstN)
      (domSel >= 8'(NUM_DOM)) |-> !clrVec[c]);
  end
  // R9: error words read zero with an out-of-range selection
  assert_oor_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((domSel >= 8'(NUM_DOM)) && regIdx[9:6] == 4'h2) |-> regRdData == 32'h0);
endmodule

bind errcap_top errcap_sva #(.NUM_CHK(NUM_CHK), .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) sva_i (
  .clk(clk), .rstN(rstN), .vioValid(vioValid), .recPend(recPend), .recAddr(recAddr),
  .clrVec(clrVec), .domSel(domSel), .regIdx(regIdx), .regRdData(regRdData)
);

// File: tb/errcap_tb.sv
module errcap_top_tb_top;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] vioValid = '0;
  logic [NC*32-1:0] vioAddr = '0;
  logic [NC*4-1:0]  vioDomain = '0;
  logic [NC*4-1:0]  vioPort = '0;
  logic [NC-1:0]    vioWrite = '0;
  logic [NC*2-1:0]  vioAttr = '0;
  logic [9:0]       regIdx = '0;
  logic             regWrEn = 1'b0;
  logic [7:0]       regWrData = '0;
  logic [31:0]      regRdData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  errcap_top dut_i (
    .clk(clk), .rstN(rstN), .vioValid(vioValid), .vioAddr(vioAddr),
    .vioDomain(vioDomain), .vioPort(vioPort), .vioWrite(vioWrite), .vioAttr(vioAttr),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic logic [9:0] bmIdx(int d);
    return 10'(16'h40 + d);
  endfunction
  function automatic logic [9:0] errIdx(int c, int w);
    return 10'(16'h80 + 4 * c + w);
  endfunction
  function automatic logic [31:0] w1(logic [1:0] st, logic [3:0] port, logic [1:0] attr,
                                     logic wr, logic [3:0] dom);
    return {st, 18'b0, port, 1'b0, attr, wr, dom};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [9:0] idx, output logic [31:0] v);
    regIdx = idx;
    #1;
    v = regRdData;
  endtask

  task automatic wr(logic [9:0] idx, logic [7:0] d);
    @(negedge clk);
    regIdx = idx; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setVio(int c, logic [31:0] a, logic [3:0] dom, logic [3:0] port,
                        logic w, logic [1:0] attr);
    vioValid[c] = 1'b1;
    vioAddr[c*32 +: 32] = a;
    vioDomain[c*4 +: 4] = dom;
    vioPort[c*4 +: 4] = port;
    vioWrite[c] = w;
    vioAttr[c*2 +: 2] = attr;
  endtask

  task automatic vio(int c, logic [31:0] a, logic [3:0] dom, logic [3:0] port,
                     logic w, logic [1:0] attr);
    @(negedge clk);
    setVio(c, a, dom, port, w, attr);
    @(negedge clk);
    vioValid = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int d = 0; d < 4; d++) begin
      rd(bmIdx(d), v); check("R2 bitmap after reset", v, 32'h0);
    end
    rd(10'd1, v); check("R2 select after reset", v, 32'h0);
    rd(10'd0, v); check("R1 config word", v, 32'h01010302);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    vio(1, 32'hDEADBEEF, 4'd2, 4'd5, 1'b1, 2'b10);
    rd(bmIdx(2), v); check("R3 R4 bitmap domain 2", v, 32'h2);
    rd(bmIdx(0), v); check("R4 bitmap domain 0 empty", v, 32'h0);
    wr(10'd1, 8'd2);
    rd(errIdx(1, 0), v); check("R6 word0 address", v, 32'hDEADBEEF);
    rd(errIdx(1, 1), v); check("R6 word1 fields", v, w1(2'b01, 4'd5, 2'b10, 1'b1, 4'd2));
    rd(errIdx(1, 2), v); check("R6 word2 zero", v, 32'h0);
  endtask

  task automatic t_first();
    logic [31:0] v;
    vio(1, 32'h00001234, 4'd0, 4'd1, 1'b0, 2'b01);
    rd(errIdx(1, 0), v); check("R7 record address kept", v, 32'hDEADBEEF);
    rd(errIdx(1, 1), v); check("R7 overrun state", v, w1(2'b11, 4'd5, 2'b10, 1'b1, 4'd2));
    rd(bmIdx(0), v); check("R7 no bit in new domain", v, 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr(10'd1, 8'd0);
    rd(errIdx(1, 0), v); check("R5 other domain reads zero", v, 32'h0);
    wr(errIdx(1, 3), 8'h01);
    rd(bmIdx(2), v); check("R8 clear under wrong domain ignored", v, 32'h2);
    wr(10'd1, 8'd2);
    wr(errIdx(1, 3), 8'h00);
    rd(bmIdx(2), v); check("R8 clear bit zero ignored", v, 32'h2);
    wr(errIdx(1, 3), 8'h01);
    rd(bmIdx(2), v); check("R8 clear accepted", v, 32'h0);
    rd(errIdx(1, 0), v); check("R5 cleared word0 zero", v, 32'h0);
  endtask

  task automatic t_recapture();
    logic [31:0] v;
    vio(1, 32'h00000055, 4'd3, 4'd1, 1'b0, 2'b01);
    rd(bmIdx(3), v); check("R11 capture after clear", v, 32'h2);
  endtask

  task automatic t_highest();
    logic [31:0] v;
    int hi;
    @(negedge clk);
    setVio(0, 32'hA0000000, 4'd3, 4'd2, 1'b0, 2'b00);
    setVio(3, 32'hC0000000, 4'd3, 4'd7, 1'b1, 2'b11);
    @(negedge clk);
    vioValid = '0;
    rd(bmIdx(3), v); check("R4 bitmap with three checkers", v, 32'hB);
    hi = -1;
    for (int i = 0; i < 32; i++) if (v[i]) hi = i;
    check("R4 highest pending checker", 32'(hi), 32'd3);
    wr(10'd1, 8'd3);
    rd(errIdx(3, 0), v); check("R5 R6 highest record address", v, 32'hC0000000);
  endtask

  task automatic t_oor();
    logic [31:0] v;
    wr(10'd1, 8'd7);
    rd(10'd1, v); check("R9 select readback", v, 32'h7);
    rd(errIdx(3, 0), v); check("R9 out-of-range word0", v, 32'h0);
    rd(errIdx(0, 1), v); check("R9 out-of-range word1", v, 32'h0);
    wr(errIdx(3, 3), 8'h01);
    rd(bmIdx(3), v); check("R9 clear ignored", v, 32'hB);
  endtask

  task automatic t_same();
    logic [31:0] v;
    wr(10'd1, 8'd3);
    @(negedge clk);
    setVio(0, 32'h00007777, 4'd1, 4'd2, 1'b1, 2'b11);
    regIdx = errIdx(0, 3); regWrData = 8'h01; regWrEn = 1'b1;
    @(negedge clk);
    vioValid = '0; regWrEn = 1'b0;
    rd(bmIdx(3), v); check("R10 old domain bit gone", v, 32'hA);
    rd(bmIdx(1), v); check("R10 new domain bit set", v, 32'h1);
    wr(10'd1, 8'd1);
    rd(errIdx(0, 0), v); check("R10 new address", v, 32'h00007777);
    rd(errIdx(0, 1), v); check("R10 new fields state 01", v, w1(2'b01, 4'd2, 2'b11, 1'b1, 4'd1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_first();
    t_window();
    t_recapture();
    t_highest();
    t_oor();
    t_same();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule